// File: doc/BRIEF.md
# ADC Acquisition and Conversion Timer

This block generates the timing for one ADC. It makes a sample-and-hold acquisition window and a one-cycle conversion-start strobe. Both repeat on a fixed period counted on a 20 MHz timebase. One 32-bit timing register holds two 10-bit fields: an acquisition length and a conversion period. The conversion rate is therefore 20 MHz divided by the period field. Software writes the register. The timer picks up new settings only at a period boundary, so a running period is never cut short or stretched.

The block also has an automatic slow-down. A single conversion may be requested on one of the three internal monitor channels, with channel codes 22, 25 and 26. When that happens, the timer loads a fixed slower setting into its own register, giving 80 kSPS. This setting stays until software writes the register again. The reload does not happen while the channel sequencer is enabled. Settings that would leave no conversion time are clamped, so at least one cycle follows the acquisition window in every period.

Top module: `adc_cnv_timer`

## Requirements
- R1: After reset, `timing_reg` reads 0x000A00C8: acquisition field 10 and period field 200. The first period starts at once with these values.
- R2: The effective period is P cycles, where P is the period field in bits 9:0 of `timing_reg`. Exactly one `cnv_pulse` occurs in each period.
- R3: In each period, `acq_win` is high for the first A cycles, where A is the acquisition field in bits 25:16. `cnv_pulse` is high for the single cycle right after the window, at cycle index A.
- R4: A write with `wr_en` loads bits 25:16 and 9:0 from `wr_data`. Bits 31:26 and 15:10 keep their previous value, which is zero after reset.
- R5: A new register value takes effect at the next period boundary. The period that is running when the write lands finishes with its old settings.
- R6: When `single_req` is high with `seq_en` low and `chan_sel` equal to 22, 25 or 26, `timing_reg` becomes 0x007D00FA on the next cycle: acquisition 125, period 250.
- R7: No reload happens while `seq_en` is high, and none happens for any other channel code.
- R8: A reloaded value stays until the next write. A write in the same cycle as a reload request wins over the reload.
- R9: If the period field is less than A+1, the effective period is A+1. A period field of 0 with an acquisition of 0 therefore gives a `cnv_pulse` every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| chan_sel | input | 5 | Currently selected input channel code |
| single_req | input | 1 | Single-conversion request |
| seq_en | input | 1 | Channel sequencer enabled |
| acq_win | output | 1 | Sample-and-hold acquisition window |
| cnv_pulse | output | 1 | One-cycle conversion-start strobe |
| timing_reg | output | 32 | Current timing register value |

## Verification
The hardest case to reach is a register change that lands in the middle of a period. A write or a reload arrives while the old period is still running, and the new values must wait until the boundary. The stimulus lines this up by waiting for a `cnv_pulse` on a short, known period and then writing a very different setting on the next cycle. It then watches the rest of the old period before the new one begins. Clamped settings are reached by writing a zero period and an acquisition longer than the period. Pulse and window cycles are then counted over whole periods.

// File: rtl/adc_cnv_timer.sv
module adc_cnv_timer #(
  parameter int REG_W   = 32,
  parameter int CNT_W   = 10,
  parameter int ACQ_LSB = 16,
  parameter int PER_LSB = 0,
  parameter int CH_W    = 5,
  parameter logic [REG_W-1:0] RST_VAL  = 32'h000A00C8,
  parameter logic [REG_W-1:0] SLOW_VAL = 32'h007D00FA,
  parameter logic [CH_W-1:0]  MON_CH_A = 5'd22,
  parameter logic [CH_W-1:0]  MON_CH_B = 5'd25,
  parameter logic [CH_W-1:0]  MON_CH_C = 5'd26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             single_req,
  input  logic             seq_en,
  output logic             acq_win,
  output logic             cnv_pulse,
  output logic [REG_W-1:0] timing_reg
);
  localparam int PW = CNT_W + 1;
  localparam logic [REG_W-1:0] FLD_MASK =
    (REG_W'({CNT_W{1'b1}}) << ACQ_LSB) | (REG_W'({CNT_W{1'b1}}) << PER_LSB);
  localparam logic [CNT_W-1:0] RST_ACQ = RST_VAL[ACQ_LSB +: CNT_W];
  localparam logic [PW-1:0]    RST_MIN = {1'b0, RST_ACQ} + PW'(1);
  localparam logic [PW-1:0]    RST_RAW = {1'b0, RST_VAL[PER_LSB +: CNT_W]};
  localparam logic [PW-1:0]    RST_PER = (RST_RAW < RST_MIN) ? RST_MIN : RST_RAW;

  logic [REG_W-1:0] cfg_q;
  logic [CNT_W-1:0] acq_a;
  logic [PW-1:0]    per_a, cnt_q;

  wire [CNT_W-1:0] new_acq = cfg_q[ACQ_LSB +: CNT_W];
  wire [PW-1:0]    new_raw = {1'b0, cfg_q[PER_LSB +: CNT_W]};
  wire [PW-1:0]    min_per = {1'b0, new_acq} + PW'(1);
  wire [PW-1:0]    eff_per = (new_raw < min_per) ? min_per : new_raw;
  wire mon_hit = (chan_sel == MON_CH_A) || (chan_sel == MON_CH_B) || (chan_sel == MON_CH_C);
  wire reload  = single_req && !seq_en && mon_hit;
  wire wrap    = (cnt_q == per_a - PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= RST_VAL;
    else if (wr_en)  cfg_q <= (cfg_q & ~FLD_MASK) | (wr_data & FLD_MASK);
    else if (reload) cfg_q <= SLOW_VAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acq_a <= RST_ACQ;
      per_a <= RST_PER;
    end else if (wrap) begin
      cnt_q <= '0;
      acq_a <= new_acq;
      per_a <= eff_per;
    end else begin
      cnt_q <= cnt_q + PW'(1);
    end
  end

  assign acq_win    = (cnt_q < {1'b0, acq_a});
  assign cnv_pulse  = (cnt_q == {1'b0, acq_a});
  assign timing_reg = cfg_q;

  a_r3_pulse_ends_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acq_win) |-> cnv_pulse);
  a_r4_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((timing_reg & ~FLD_MASK) == $past(timing_reg & ~FLD_MASK)));
  a_r6_monitor_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !wr_en) |=> (timing_reg == SLOW_VAL));
  a_r7_seq_blocks_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && !wr_en) |=> $stable(timing_reg));
  a_r8_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !single_req) |=> $stable(timing_reg));
  a_r5_no_mid_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(acq_a) && $stable(per_a)));
  a_r9_conversion_room: assert property (@(posedge clk) disable iff (!rst_n)
    per_a > {1'b0, acq_a});
endmodule

// File: tb/adc_cnv_timer_bench.sv
module adc_cnv_timer_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, single_req = 0, seq_en = 0;
  logic [31:0] wr_data = 0;
  logic [4:0] chan_sel = 0;
  logic acq_win, cnv_pulse;
  logic [31:0] timing_reg;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  adc_cnv_timer u_adc_cnv_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .chan_sel(chan_sel), .single_req(single_req), .seq_en(seq_en), .acq_win(acq_win),
    .cnv_pulse(cnv_pulse), .timing_reg(timing_reg));

  always #4 clk = ~clk;

  // behavioural reference
  int m_reg, m_acq, m_per, m_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 32'h000A00C8; m_acq = 10; m_per = 200; m_cnt = 0;
    end else begin
      if (m_cnt == m_per - 1) begin
        m_cnt = 0;
        m_acq = (m_reg >> 16) & 1023;
        m_per = m_reg & 1023;
        if (m_per < m_acq + 1) m_per = m_acq + 1;
      end else m_cnt++;
      if (wr_en) m_reg = (m_reg & 32'hFC00FC00) | (wr_data & 32'h03FF03FF);
      else if (single_req && !seq_en && (chan_sel == 22 || chan_sel == 25 || chan_sel == 26))
        m_reg = 32'h007D00FA;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cyc++;
    chk("R3", "acq_win", acq_win, m_cnt < m_acq);
    chk("R2", "cnv_pulse", cnv_pulse, m_cnt == m_acq);
    chk("R4", "timing_reg", timing_reg, m_reg);
  end

  task automatic step(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic [31:0] d);
    wr_en = 1; wr_data = d; step(1); wr_en = 0;
  endtask

  int npulse, nacq;
  initial begin
    step(2); rst_n = 1; step(1);
    chk("R1", "reset reg", timing_reg, 32'h000A00C8);
    chk("R1", "window at start", acq_win, 1);
    step(250);
    wr(32'hFFFFFFFF);
    chk("R4", "reserved bits", timing_reg, 32'h03FF03FF);
    wr(32'h00030008);
    step(1100);
    // R2 and R3: count over 10 periods of 8
    npulse = 0; nacq = 0;
    for (int i = 0; i < 80; i++) begin npulse += cnv_pulse; nacq += acq_win; step(1); end
    chk("R2", "pulses in 80 cycles", npulse, 10);
    chk("R3", "window cycles in 80", nacq, 30);
    // R5: mid-period write
    wr(32'h00020014);
    step(40);
    while (!cnv_pulse) step(1);
    wr(32'h000A001E);
    nacq = 0; npulse = 0;
    for (int i = 0; i < 15; i++) begin nacq += acq_win; npulse += cnv_pulse; step(1); end
    chk("R5", "old period unchanged", nacq + npulse, 0);
    step(40);
    // R6 reload
    chan_sel = 25; single_req = 1; step(1); single_req = 0;
    chk("R6", "reload ch25", timing_reg, 32'h007D00FA);
    wr(32'h00010004);
    chan_sel = 22; seq_en = 1; single_req = 1; step(1); single_req = 0; seq_en = 0;
    chk("R7", "seq blocks reload", timing_reg, 32'h00010004);
    chan_sel = 21; single_req = 1; step(1); single_req = 0;
    chk("R7", "other channel", timing_reg, 32'h00010004);
    chan_sel = 26; single_req = 1; step(1); single_req = 0;
    chk("R6", "reload ch26", timing_reg, 32'h007D00FA);
    step(60);
    chk("R8", "reload persists", timing_reg, 32'h007D00FA);
    chan_sel = 22; single_req = 1; wr(32'h00000000); single_req = 0;
    chk("R8", "write beats reload", timing_reg, 32'h00000000);
    // R9: zero period and acquisition
    step(300);
    npulse = 0;
    for (int i = 0; i < 10; i++) begin npulse += cnv_pulse; step(1); end
    chk("R9", "pulse every cycle", npulse, 10);
    wr(32'h00060004);
    step(20);
    npulse = 0; nacq = 0;
    for (int i = 0; i < 70; i++) begin npulse += cnv_pulse; nacq += acq_win; step(1); end
    chk("R9", "clamped pulses", npulse, 10);
    chk("R9", "clamped window", nacq, 60);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run did not end");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule